// File: doc/BRIEF.md
# Shadow register copy sequencer

This block sits between a fast register file and an always-on persistent domain. Software writes any of eight registers (six general persistent words, an alarm word and a seconds word) through per-register write strobes. Each write lands at once in a fast-side shadow copy and marks that register stale. A slow copy-clock enable, modelled here as a one-cycle pulse on the same clock, moves pending shadow values into the persistent side one register per pulse.

Software learns about progress through a 32-bit status word. A stale field shows which registers still wait for their copy. A new-value field shows which persistent copies have been refreshed since the last status read. The usual pattern is to write the seconds word, then poll its stale bit until it drops before trusting a read of the persistent seconds value.

Pending copies are serviced in a fixed priority order. The lowest register index goes first, so the seconds word, at index 7, is always served last.

Top module: `shadow_copy_seq`

## Requirements
- R1: Register index i is 0..5 for the persistent words, 6 for alarm and 7 for seconds. In the status word, bit 16+i is the stale bit and bit 8+i is the new-value bit of register i, so seconds stale is mask 0x80 in the field at bits 23:16. All other status bits read zero.
- R2: A write strobe on register i stores the data in its shadow and sets its stale bit at the same clock edge.
- R3: A copy pulse while any register is stale copies exactly one register, the lowest-numbered stale one, into its persistent value at that edge, and clears that stale bit.
- R4: Without a copy pulse, no persistent value changes and stale bits are only ever set.
- R5: A second write to a register that is still stale replaces the shadow data, and the later copy carries the newest value.
- R6: If a register is written in the same cycle that its copy fires, the copy carries the previous shadow value, the register stays stale, and the new value is copied by a later pulse.
- R7: A completed copy sets that register's new-value bit. A status read strobe clears all new-value bits, except that a copy completing in the same cycle leaves its own bit set.
- R8: Out of reset, the stale field, the new-value field and every persistent value are zero.
- R9: With all eight registers stale, the seconds word lands on the eighth copy pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 8 | Per-register write strobe, bit i for register i |
| wr_data_flat | input | 8*DATA_W | Write data, register i at bits i*DATA_W +: DATA_W |
| copy_tick | input | 1 | Slow copy-clock enable, one copy per high cycle |
| stat_rd | input | 1 | Status read strobe, clears new-value bits |
| stat_word | output | 32 | Status word with stale and new-value fields |
| pers_q | output | 8*DATA_W | Persistent-side values, same packing as wr_data_flat |

## Verification
The assertions assume that reset is synchronous and held for at least one edge. They also assume that a status read and a copy pulse each count as one event per high cycle, so a strobe held for several cycles counts as several reads or copies. Write strobes may hit any mix of registers in any cycle, including the one being copied. The stimulus changes every input only on the falling clock edge and returns the strobes to zero after each event, so each pulse means exactly one copy or one read. The collision cases, a write or a read in the same cycle as a copy, are driven on purpose.

// File: rtl/shcs_pkg.sv
package shcs_pkg;
  localparam int SC_NREG    = 8;
  localparam int SC_STAT_W  = 32;
  localparam int SC_NEW_LSB = 8;
  localparam int SC_STL_LSB = 16;

  // Build the status word from the two per-register fields.
  function automatic logic [SC_STAT_W-1:0] pack_status(
    input logic [SC_NREG-1:0] stale,
    input logic [SC_NREG-1:0] fresh
  );
    logic [SC_STAT_W-1:0] w;
    w = '0;
    w[SC_STL_LSB +: SC_NREG] = stale;
    w[SC_NEW_LSB +: SC_NREG] = fresh;
    return w;
  endfunction

  // One-hot of the lowest set bit, zero when none is set.
  function automatic logic [SC_NREG-1:0] lowest_onehot(input logic [SC_NREG-1:0] req);
    logic [SC_NREG-1:0] g;
    g = '0;
    for (int i = SC_NREG - 1; i >= 0; i--) begin
      if (req[i]) begin
        g    = '0;
        g[i] = 1'b1;
      end
    end
    return g;
  endfunction
endpackage

// File: rtl/shcs_shadow_bank.sv
module shcs_shadow_bank #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREG-1:0]        wr_en,
  input  logic [NREG*DATA_W-1:0] wr_data_flat,
  input  logic [NREG-1:0]        copy_done,
  output logic [NREG*DATA_W-1:0] shadow_flat,
  output logic [NREG-1:0]        stale
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_flat[i*DATA_W +: DATA_W] <= '0;
        stale[i]                        <= 1'b0;
      end else if (wr_en[i]) begin
        // A write wins over a copy of the same register in this cycle.
        shadow_flat[i*DATA_W +: DATA_W] <= wr_data_flat[i*DATA_W +: DATA_W];
        stale[i]                        <= 1'b1;
      end else if (copy_done[i]) begin
        stale[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shcs_copy_pick.sv
module shcs_copy_pick #(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0] stale,
  input  logic            copy_tick,
  output logic [NREG-1:0] grant
);
  logic [NREG-1:0] lowest;
  always_comb begin
    lowest = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (stale[i]) begin
        lowest    = '0;
        lowest[i] = 1'b1;
      end
    end
    grant = copy_tick ? lowest : '0;
  end
endmodule

// File: rtl/shcs_persist_bank.sv
module shcs_persist_bank #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREG-1:0]        grant,
  input  logic [NREG*DATA_W-1:0] shadow_flat,
  input  logic                   stat_rd,
  output logic [NREG*DATA_W-1:0] pers_flat,
  output logic [NREG-1:0]        fresh
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pers_flat[i*DATA_W +: DATA_W] <= '0;
        fresh[i]                      <= 1'b0;
      end else if (grant[i]) begin
        pers_flat[i*DATA_W +: DATA_W] <= shadow_flat[i*DATA_W +: DATA_W];
        fresh[i]                      <= 1'b1;
      end else if (stat_rd) begin
        fresh[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shadow_copy_seq.sv
module shadow_copy_seq #(
  parameter int DATA_W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [shcs_pkg::SC_NREG-1:0]           wr_en,
  input  logic [shcs_pkg::SC_NREG*DATA_W-1:0]    wr_data_flat,
  input  logic                                   copy_tick,
  input  logic                                   stat_rd,
  output logic [shcs_pkg::SC_STAT_W-1:0]         stat_word,
  output logic [shcs_pkg::SC_NREG*DATA_W-1:0]    pers_q
);
  localparam int NREG = shcs_pkg::SC_NREG;

  logic [NREG*DATA_W-1:0] shadow_flat;
  logic [NREG-1:0]        stale_bits;
  logic [NREG-1:0]        fresh_bits;
  logic [NREG-1:0]        copy_grant;
  logic                   copy_fire;

  assign copy_fire = |copy_grant;

  shcs_shadow_bank #(.NREG(NREG), .DATA_W(DATA_W)) shadow_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data_flat (wr_data_flat),
    .copy_done    (copy_grant),
    .shadow_flat  (shadow_flat),
    .stale        (stale_bits)
  );

  shcs_copy_pick #(.NREG(NREG)) pick_i (
    .stale     (stale_bits),
    .copy_tick (copy_tick),
    .grant     (copy_grant)
  );

  shcs_persist_bank #(.NREG(NREG), .DATA_W(DATA_W)) persist_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant       (copy_grant),
    .shadow_flat (shadow_flat),
    .stat_rd     (stat_rd),
    .pers_flat   (pers_q),
    .fresh       (fresh_bits)
  );

  assign stat_word = shcs_pkg::pack_status(stale_bits, fresh_bits);
endmodule

// File: rtl/shcs_checker.sv
module shcs_checker #(
  parameter int DATA_W = 32
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [shcs_pkg::SC_NREG-1:0]        wr_en,
  input logic                                copy_tick,
  input logic                                stat_rd,
  input logic [shcs_pkg::SC_STAT_W-1:0]      stat_word,
  input logic [shcs_pkg::SC_NREG*DATA_W-1:0] pers_q,
  input logic [shcs_pkg::SC_NREG-1:0]        copy_grant,
  input logic                                copy_fire
);
  localparam int NREG = shcs_pkg::SC_NREG;
  logic [NREG-1:0] stl;
  logic [NREG-1:0] frs;
  logic [shcs_pkg::SC_STAT_W-1:0] spare;
  assign stl   = stat_word[shcs_pkg::SC_STL_LSB +: NREG];
  assign frs   = stat_word[shcs_pkg::SC_NEW_LSB +: NREG];
  assign spare = shcs_pkg::pack_status(stl, frs) ^ stat_word;

  // R1: nothing outside the two fields is ever set
  a_r1_spare_zero: assert property (@(posedge clk) disable iff (!rst_n) spare == '0);
  // R2: a strobed register reads stale after the edge
  a_r2_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0) |=> ((stl & $past(wr_en)) == $past(wr_en)));
  // R3: at most one register per pulse
  a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(copy_grant));
  // R3: a pulse with work pending always copies
  a_r3_tick_serves: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_tick && stl != '0) |-> copy_fire);
  // R3: no lower-numbered register is left waiting
  a_r3_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    copy_fire |-> ((NREG'(copy_grant - 1'b1) & stl) == '0));
  // R3: the served register is grant of a stale one
  a_r3_grant_is_stale: assert property (@(posedge clk) disable iff (!rst_n)
    ((copy_grant & ~stl) == '0));
  // R3/R6: the copied register drops stale unless rewritten in that cycle
  a_r3_stale_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_fire && ((wr_en & copy_grant) == '0)) |=> ((stl & $past(copy_grant)) == '0));
  // R4: no pulse, no copy, persistent side frozen
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_tick |-> (copy_grant == '0));
  a_r4_pers_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_fire |=> $stable(pers_q));
  // R7: a finished copy shows in the new-value field
  a_r7_fresh_set: assert property (@(posedge clk) disable iff (!rst_n)
    copy_fire |=> ((frs & $past(copy_grant)) == $past(copy_grant)));
  // R7: a read with no copy empties the new-value field
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !copy_fire) |=> (frs == '0));
  // R8: reset leaves the status word empty
  a_r8_reset_state: assert property (@(posedge clk)
    !rst_n |=> (stat_word == '0 && pers_q == '0));
endmodule

bind shadow_copy_seq shcs_checker #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .copy_tick  (copy_tick),
  .stat_rd    (stat_rd),
  .stat_word  (stat_word),
  .pers_q     (pers_q),
  .copy_grant (copy_grant),
  .copy_fire  (copy_fire)
);

// File: tb/shadow_copy_seq_tb.sv
module shadow_copy_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NR = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NR-1:0]     wr_en = '0;
  logic [NR*DW-1:0]  wr_data_flat = '0;
  logic              copy_tick = 1'b0;
  logic              stat_rd = 1'b0;
  logic [31:0]       stat_word;
  logic [NR*DW-1:0]  pers_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_copy_seq #(.DATA_W(DW)) dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data_flat (wr_data_flat),
    .copy_tick (copy_tick), .stat_rd (stat_rd), .stat_word (stat_word), .pers_q (pers_q)
  );

  function automatic logic [7:0] stale_f(); return stat_word[23:16]; endfunction
  function automatic logic [7:0] new_f();   return stat_word[15:8];  endfunction
  function automatic logic [31:0] pers(int i); return pers_q[i*DW +: DW]; endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Inputs change on the falling edge; results are read at the next falling edge.
  task automatic step(); @(negedge clk); endtask

  task automatic put(int i, logic [31:0] d);
    wr_en[i] = 1'b1;
    wr_data_flat[i*DW +: DW] = d;
  endtask

  task automatic release_all();
    wr_en = '0; copy_tick = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic do_write(int i, logic [31:0] d);
    put(i, d); step(); release_all();
  endtask

  task automatic do_tick();
    copy_tick = 1'b1; step(); release_all();
  endtask

  task automatic do_read();
    stat_rd = 1'b1; step(); release_all();
  endtask

  task automatic t_reset();
    chk("R8", "status after reset", stat_word, 0);
    chk("R8", "persistent after reset", pers_q, 0);
    do_tick();
    chk("R8", "tick with nothing stale keeps status zero", stat_word, 0);
  endtask

  task automatic t_seconds();
    do_write(7, 32'h1234_5678);
    chk("R2", "seconds stale bit", stale_f(), 8'h80);
    chk("R1", "seconds stale mask in word", stat_word, 32'h0080_0000);
    step(); step(); step();
    chk("R4", "stale held without pulse", stale_f(), 8'h80);
    chk("R4", "seconds not copied without pulse", pers(7), 0);
    do_tick();
    chk("R3", "seconds copied", pers(7), 32'h1234_5678);
    chk("R3", "seconds stale cleared", stale_f(), 8'h00);
    chk("R7", "seconds new bit", new_f(), 8'h80);
    chk("R1", "new-value mask in word", stat_word, 32'h0000_8000);
    do_read();
    chk("R7", "read clears new bits", new_f(), 8'h00);
  endtask

  task automatic t_priority();
    put(0, 32'hA0); put(2, 32'hA2); put(6, 32'hA6); put(7, 32'hA7);
    step(); release_all();
    chk("R2", "four registers stale", stale_f(), 8'hC5);
    do_tick();
    chk("R3", "persistent 0 first", pers(0), 32'hA0);
    chk("R3", "others untouched after first", pers(2), 0);
    chk("R3", "stale after first", stale_f(), 8'hC4);
    do_tick();
    chk("R3", "persistent 2 second", pers(2), 32'hA2);
    chk("R3", "alarm still waiting", pers(6), 0);
    do_tick();
    chk("R3", "alarm third", pers(6), 32'hA6);
    chk("R3", "seconds still stale", stale_f(), 8'h80);
    do_tick();
    chk("R3", "seconds last", pers(7), 32'hA7);
    chk("R7", "new bits collected", new_f(), 8'hC5);
    do_read();
  endtask

  task automatic t_rewrite();
    do_write(3, 32'h0000_1111);
    do_write(3, 32'h0000_2222);
    chk("R5", "still one stale bit", stale_f(), 8'h08);
    do_tick();
    chk("R5", "latest value copied", pers(3), 32'h0000_2222);
    do_read();
  endtask

  task automatic t_collide();
    do_write(1, 32'h0000_00B1);
    put(1, 32'h0000_00B2); copy_tick = 1'b1; step(); release_all();
    chk("R6", "collision copies old value", pers(1), 32'h0000_00B1);
    chk("R6", "register stays stale", stale_f(), 8'h02);
    do_tick();
    chk("R6", "new value copied later", pers(1), 32'h0000_00B2);
    chk("R6", "stale cleared after second copy", stale_f(), 8'h00);
    do_read();
  endtask

  task automatic t_read_collide();
    do_write(5, 32'h55);
    do_tick();
    do_write(4, 32'h44);
    chk("R7", "new bit of 5 before read", new_f(), 8'h20);
    stat_rd = 1'b1; copy_tick = 1'b1; step(); release_all();
    chk("R7", "copy beats read for its own bit", new_f(), 8'h10);
    do_read();
    chk("R7", "plain read clears", new_f(), 8'h00);
  endtask

  task automatic t_drain();
    int n = 0;
    for (int i = 0; i < NR; i++) put(i, 32'hC000_0000 + i);
    step(); release_all();
    chk("R9", "all stale", stale_f(), 8'hFF);
    while (stale_f()[7] && n < 20) begin
      do_tick();
      n++;
    end
    chk("R9", "seconds lands on eighth pulse", n, 8);
    chk("R9", "seconds value", pers(7), 32'hC000_0007);
    chk("R9", "persistent 5 value", pers(5), 32'hC000_0005);
    do_read();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_seconds();
    t_priority();
    t_rewrite();
    t_collide();
    t_read_collide();
    t_drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule